// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits beside the fetch stage and guesses the next fetch address in the same cycle as the fetch. The current PC splits into a row index and a tag. If the addressed row holds a valid entry with a matching tag, the stored target becomes the next fetch address. Otherwise fetch falls through to PC+4. The block never judges whether a branch is taken. It only remembers where a branch went the last time it was resolved.

After decode resolves a branch, it presents the branch PC and the computed target on the update port. That pair is written into the row the PC indexes, and it overwrites whatever the row held before. A branch seen for the first time therefore misses once and hits on later visits. Two branches that share index bits evict each other, and the tag compare keeps a lookup from ever returning another branch's target.

Top module: `btb_direct`

## Requirements
- R1: While `rst` is high at a rising edge, every valid flag clears. After that edge, every lookup misses until an update is written. Reset takes priority over an update in the same cycle.
- R2: The row index is PC[7:2] (64 rows). The tag is PC[31:8]. Lookups and updates use the same split.
- R3: On a hit, `lk_hit` is 1 and `lk_next_pc` equals `lk_target`, in the same cycle the PC is presented.
- R4: On a miss (the row is not valid, or its tag differs), `lk_hit` is 0, `lk_next_pc` is `lk_pc`+4 (modulo 2^32), and `lk_target` is 0.
- R5: When `up_en` is high at a rising edge, the row for `up_pc` is written with its tag and target. From the next cycle on, a lookup of that PC hits and returns that target.
- R6: A lookup of the row being written in the same cycle sees the contents from before the write.
- R7: When a branch is written into a row that holds another branch with the same index, the older entry is replaced. For example, after 0x1080 and then 0x1880 are written, a lookup of 0x1080 misses.
- R8: The stored target keeps `up_target[31:2]`, and bits [1:0] of `lk_target` are always 0.
- R9: Bits [1:0] of a lookup PC do not affect the hit decision. On a miss, PC+4 is formed from the full PC.
- R10: A second update of the same PC replaces the target returned by later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid flags |
| lk_pc | input | 32 | PC of the instruction being fetched |
| lk_hit | output | 1 | The indexed row is valid and its tag matches |
| lk_next_pc | output | 32 | Predicted next fetch address |
| lk_target | output | 32 | Stored target on a hit, 0 on a miss |
| up_en | input | 1 | Write a resolved branch this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_target | input | 32 | Computed target of the resolved branch |

## Verification
The hardest cases to reach from the ports involve timing and collisions. One is a write and a lookup that land on the same row in the same clock. Another is two different branches fighting over one row. The directed stimulus writes 0x1080 while looking it up in that same cycle. It then brings in 0x1880, which has the same index, and checks that the older branch now misses. After that, a long random phase confines both the lookup and the update PCs to four tag values over eight rows, with random low bits. This keeps same-cycle read/write overlaps, evictions and re-installs happening constantly. Every cycle is compared against a reference model kept as an associative array keyed by row.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Default geometry of the buffer
  localparam int DEF_PC_W  = 32;
  localparam int DEF_IDX_W = 6;
  // Instructions are four bytes wide
  localparam int INSTR_BYTES = 4;
  localparam int OFS_W = $clog2(INSTR_BYTES);
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = btb_pkg::DEF_PC_W,
  parameter int IDX_W = btb_pkg::DEF_IDX_W,
  localparam int OFS_W = btb_pkg::OFS_W,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  // Skip the byte offset, take the row bits, keep the rest as identity
  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_valid_bits.sv
module btb_valid_bits #(
  parameter int IDX_W = btb_pkg::DEF_IDX_W,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [ROWS-1:0] vld_q;

  // One flop per row so that reset can clear them all in one cycle
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        vld_q[r] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(r)))
        vld_q[r] <= 1'b1;
    end
  end

  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int IDX_W  = btb_pkg::DEF_IDX_W,
  parameter int DATA_W = 54,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  // Tag and target rows: no reset, asynchronous read (distributed RAM)
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int PC_W  = btb_pkg::DEF_PC_W,
  parameter int IDX_W = btb_pkg::DEF_IDX_W,
  localparam int OFS_W = btb_pkg::OFS_W,
  localparam int TAG_W = PC_W - IDX_W - OFS_W,
  localparam int TGT_W = PC_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [TAG_W-1:0] pc_tag,
  input  logic             row_valid,
  input  logic [TAG_W-1:0] row_tag,
  input  logic [TGT_W-1:0] row_tgt,
  output logic             hit,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  target
);
  localparam logic [PC_W-1:0] STEP = PC_W'(btb_pkg::INSTR_BYTES);

  always_comb begin
    hit = row_valid && (row_tag == pc_tag);
    target = '0;
    next_pc = pc + STEP;
    if (hit) begin
      target  = {row_tgt, {OFS_W{1'b0}}};
      next_pc = target;
    end
  end
endmodule

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int PC_W  = btb_pkg::DEF_PC_W,
  parameter int IDX_W = btb_pkg::DEF_IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_next_pc,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_target
);
  localparam int OFS_W  = btb_pkg::OFS_W;
  localparam int TAG_W  = PC_W - IDX_W - OFS_W;
  localparam int TGT_W  = PC_W - OFS_W;
  localparam int DATA_W = TAG_W + TGT_W;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              row_valid;
  logic [DATA_W-1:0] row_data, wr_data;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_up (
    .pc(up_pc), .idx(up_idx), .tag(up_tag)
  );

  // Entry layout: tag in the upper part, word-aligned target below it
  assign wr_data = {up_tag, up_target[PC_W-1:OFS_W]};

  btb_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk(clk), .rst(rst), .wr_en(up_en), .wr_idx(up_idx),
    .rd_idx(lk_idx), .rd_valid(row_valid)
  );

  // The table has no reset, so writes during reset are dropped here too
  btb_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(up_en && !rst), .wr_idx(up_idx), .wr_data(wr_data),
    .rd_idx(lk_idx), .rd_data(row_data)
  );

  btb_match #(.PC_W(PC_W), .IDX_W(IDX_W)) u_match (
    .pc(lk_pc), .pc_tag(lk_tag), .row_valid(row_valid),
    .row_tag(row_data[DATA_W-1 -: TAG_W]), .row_tgt(row_data[TGT_W-1:0]),
    .hit(lk_hit), .next_pc(lk_next_pc), .target(lk_target)
  );
endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic [PC_W-1:0] lk_next_pc,
  input logic [PC_W-1:0] lk_target,
  input logic            up_en,
  input logic [PC_W-1:0] up_pc,
  input logic [PC_W-1:0] up_target
);
  // R1
  after_reset_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R3
  hit_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_next_pc == lk_target);

  // R4
  miss_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(4)) && (lk_target == '0));

  // R8
  target_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    lk_target[1:0] == 2'b00);

  // R5
  update_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(up_en) && !$past(rst) && (lk_pc[PC_W-1:2] == $past(up_pc[PC_W-1:2])))
      |-> lk_hit && (lk_target == {$past(up_target[PC_W-1:2]), 2'b00}));
endmodule

bind btb_direct btb_direct_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit),
  .lk_next_pc(lk_next_pc), .lk_target(lk_target), .up_en(up_en),
  .up_pc(up_pc), .up_target(up_target)
);

// File: tb/btb_direct_test.sv
module btb_direct_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic [31:0] lk_next_pc, lk_target;
  logic        up_en = 1'b0;
  logic [31:0] up_pc = '0, up_target = '0;

  int checks = 0;
  int errors = 0;

  // Reference model: row number -> branch word address / target word address
  logic [29:0] ref_pcw [int];
  logic [29:0] ref_tgw [int];

  always #5 clk = ~clk;

  btb_direct uut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_next_pc(lk_next_pc), .lk_target(lk_target), .up_en(up_en),
    .up_pc(up_pc), .up_target(up_target)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare, then commit to the model
  task automatic step(string req, logic [31:0] lpc, logic ue,
                      logic [31:0] upc, logic [31:0] utg, logic do_rst = 1'b0);
    int row;
    logic e_hit;
    logic [31:0] e_tgt, e_next;
    @(negedge clk);
    lk_pc = lpc; up_en = ue; up_pc = upc; up_target = utg; rst = do_rst;
    #1;
    // R2: row from PC[7:2], identity from PC[31:8]
    row = int'((lpc >> 2) % 64);
    e_hit = ref_pcw.exists(row) && ((ref_pcw[row] >> 6) == 30'(lpc >> 8));
    e_tgt = e_hit ? {ref_tgw[row], 2'b00} : 32'h0;
    e_next = e_hit ? e_tgt : lpc + 32'd4;
    if (!do_rst) begin
      check(req, "hit", {31'b0, lk_hit}, {31'b0, e_hit});
      check(req, "next_pc", lk_next_pc, e_next);
      check(req, "target", lk_target, e_tgt);
    end
    @(posedge clk);
    if (do_rst) begin
      ref_pcw.delete();
      ref_tgw.delete();
    end else if (ue) begin
      row = int'((upc >> 2) % 64);
      ref_pcw[row] = upc[31:2];
      ref_tgw[row] = utg[31:2];
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset, with an update offered during reset that must be dropped
    step("R1", 32'h1080, 1'b0, 32'h0, 32'h0, 1'b1);
    step("R1", 32'h1080, 1'b1, 32'h1080, 32'h5000, 1'b1);
    step("R1", 32'h1080, 1'b0, 32'h0, 32'h0, 1'b1);
    step("R1", 32'h1080, 1'b0, 32'h0, 32'h0);
    check("R1", "hit after reset", {31'b0, lk_hit}, 32'h0);
    // R6: write and look up the same row in one cycle
    step("R6", 32'h1080, 1'b1, 32'h1080, 32'h2000);
    check("R6", "same-cycle old view", {31'b0, lk_hit}, 32'h0);
    // R5 / R3: visible next cycle, redirect to target
    step("R5", 32'h1080, 1'b0, 32'h0, 32'h0);
    check("R3", "next_pc on hit", lk_next_pc, 32'h2000);
    // R4: neighbour row misses, falls through
    step("R4", 32'h1084, 1'b0, 32'h0, 32'h0);
    check("R4", "fallthrough", lk_next_pc, 32'h1088);
    step("R4", 32'hFFFF_FFFC, 1'b0, 32'h0, 32'h0);
    check("R4", "wraparound", lk_next_pc, 32'h0);
    // R7 / R8: aliasing branch with unaligned target
    step("R7", 32'h1880, 1'b1, 32'h1880, 32'h3003);
    step("R8", 32'h1880, 1'b0, 32'h0, 32'h0);
    check("R8", "aligned target", lk_target, 32'h3000);
    step("R7", 32'h1080, 1'b0, 32'h0, 32'h0);
    check("R7", "evicted branch", {31'b0, lk_hit}, 32'h0);
    // R10: retarget same branch
    step("R10", 32'h1880, 1'b1, 32'h1880, 32'h4000);
    step("R10", 32'h1880, 1'b0, 32'h0, 32'h0);
    check("R10", "new target", lk_target, 32'h4000);
    // R9: low PC bits ignored for the hit
    step("R9", 32'h1882, 1'b0, 32'h0, 32'h0);
    check("R9", "hit with low bits", {31'b0, lk_hit}, 32'h1);
    step("R9", 32'h1083, 1'b0, 32'h0, 32'h0);
    check("R9", "miss next from full pc", lk_next_pc, 32'h1087);
    // R1: reset again wipes the table
    step("R1", 32'h1880, 1'b0, 32'h0, 32'h0, 1'b1);
    step("R1", 32'h1880, 1'b0, 32'h0, 32'h0);
    check("R1", "hit after second reset", {31'b0, lk_hit}, 32'h0);
    // R2 R5 R6 R7: random traffic over 4 tags x 8 rows
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] lp, upc;
      lp  = 32'h1000 + (($urandom % 4) << 11) + (($urandom % 8) << 2) + ($urandom % 4);
      upc = 32'h1000 + (($urandom % 4) << 11) + (($urandom % 8) << 2) + ($urandom % 4);
      step("R2", lp, 1'($urandom % 2), upc, $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule